// File: doc/BRIEF.md
# Interrupt Status Register Bank

This block gathers the interrupt sources of a peripheral into one small register set that software reaches through a plain address, write-data and write-strobe port. Every bit position is fixed at elaboration as one of two kinds. An event bit latches a one-cycle hardware pulse and keeps it until software clears it. A level bit shows a hardware condition as it stands, and software cannot change it.

Four addresses are decoded. Address 0 holds the raw status. Address 1 holds the masked status, which is read-only. Address 2 is the enable-set register and address 3 is the enable-clear register. Software changes the enable mask only by writing ones to the set or clear address, so there is no read-modify-write of a single mask register. The masked status is always the raw status ANDed with the enable mask. The single interrupt output is a registered copy of "masked status is nonzero". Enables never change the raw status.

Top module: `isr_bank`

## Requirements
- R1: While reset is high, the enable mask, every event bit, `irq` and `reg_rdata` are cleared to 0.
- R2: Reading address 1 returns exactly the raw status ANDed with the enable mask.
- R3: `irq` is a register. It is 1 in a cycle exactly when the masked status was nonzero in the previous cycle, so it follows a status or enable change one cycle later.
- R4: Setting or clearing enable bits leaves the raw status value (address 0) unchanged.
- R5: A 1 on an event bit's `evt_pulse` input sets that raw bit on the next clock edge, and the bit stays set after the pulse ends.
- R6: Writing to address 0 clears each event bit whose `reg_wdata` bit is 1. Bits written with 0 keep their value.
- R7: When a hardware pulse and a software clear reach the same event bit in the same cycle, the bit ends up set.
- R8: A level bit of the raw status always equals its `lvl_cond` input. Writes to address 0 or address 1 have no effect on it.
- R9: Writing to address 2 sets each enable bit whose `reg_wdata` bit is 1, and bits written with 0 keep their value. Reading address 2 or address 3 returns the current enable mask.
- R10: Writing to address 3 clears each enable bit whose `reg_wdata` bit is 1, and bits written with 0 keep their value.
- R11: `reg_rdata` is registered. It shows the register selected by `reg_addr` as it stood at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | N_BITS | Hardware event pulses; used only at event positions |
| lvl_cond | input | N_BITS | Hardware level conditions; used only at level positions |
| reg_addr | input | 2 | Register select: 0 raw, 1 masked, 2 enable-set, 3 enable-clear |
| reg_wdata | input | N_BITS | Write data |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_rdata | output | N_BITS | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Two functions can land on the same event bit in the same cycle: the hardware pulse that sets it and the software write-one that clears it. The bench drives `evt_pulse` and a write to address 0 with the same bit in the same cycle, then reads the raw status back and expects that bit to be 1. It checks the other event bits to confirm they are untouched. A second overlap case is a level input that changes while the enable for its bit is being set. Here the bench checks that `irq` follows the result one cycle after the change and not in the same cycle.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_RAW    = 2'd0,
    RA_MASKED = 2'd1,
    RA_EN_SET = 2'd2,
    RA_EN_CLR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/isr_status_bits.sv
module isr_status_bits #(
  parameter int              N_BITS     = 8,
  parameter logic [N_BITS-1:0] EVENT_MASK = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_BITS-1:0] evt_pulse,
  input  logic [N_BITS-1:0] lvl_cond,
  input  logic              clr_stb,
  input  logic [N_BITS-1:0] clr_bits,
  output logic [N_BITS-1:0] raw_o
);
  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    if (EVENT_MASK[i]) begin : g_event
      logic hold_q;
      logic wipe;
      assign wipe = clr_stb & clr_bits[i];
      // a pulse arriving with a clear keeps the bit set
      always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else     hold_q <= evt_pulse[i] | (hold_q & ~wipe);
      end
      assign raw_o[i] = hold_q;
    end else begin : g_level
      assign raw_o[i] = lvl_cond[i];
    end
  end
endmodule

// File: rtl/isr_enable_mask.sv
module isr_enable_mask #(
  parameter int N_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic              clr_stb,
  input  logic [N_BITS-1:0] bits,
  output logic [N_BITS-1:0] en_o
);
  logic [N_BITS-1:0] en_q;
  logic [N_BITS-1:0] set_v;
  logic [N_BITS-1:0] clr_v;

  assign set_v = set_stb ? bits : '0;
  assign clr_v = clr_stb ? bits : '0;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | set_v) & ~clr_v;
  end

  assign en_o = en_q;
endmodule

// File: rtl/isr_read_port.sv
module isr_read_port #(
  parameter int N_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  isr_pkg::reg_sel_e    sel,
  input  logic [N_BITS-1:0]    raw,
  input  logic [N_BITS-1:0]    masked,
  input  logic [N_BITS-1:0]    en,
  output logic [N_BITS-1:0]    rdata
);
  import isr_pkg::*;
  logic [N_BITS-1:0] mux_v;

  always_comb begin
    unique case (sel)
      RA_RAW:    mux_v = raw;
      RA_MASKED: mux_v = masked;
      default:   mux_v = en;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mux_v;
  end
endmodule

// File: rtl/isr_bank.sv
module isr_bank #(
  parameter int                N_BITS     = 8,
  parameter logic [N_BITS-1:0] EVENT_MASK = 8'h0F
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_BITS-1:0]             evt_pulse,
  input  logic [N_BITS-1:0]             lvl_cond,
  input  logic [isr_pkg::REG_ADDR_W-1:0] reg_addr,
  input  logic [N_BITS-1:0]             reg_wdata,
  input  logic                          reg_wr,
  output logic [N_BITS-1:0]             reg_rdata,
  output logic                          irq
);
  import isr_pkg::*;

  reg_sel_e          sel;
  logic [N_BITS-1:0] raw_vec;
  logic [N_BITS-1:0] en_vec;
  logic [N_BITS-1:0] masked_vec;
  logic              wr_raw;
  logic              wr_set;
  logic              wr_clr;

  assign sel    = reg_sel_e'(reg_addr);
  assign wr_raw = reg_wr && (sel == RA_RAW);
  assign wr_set = reg_wr && (sel == RA_EN_SET);
  assign wr_clr = reg_wr && (sel == RA_EN_CLR);

  isr_status_bits #(.N_BITS(N_BITS), .EVENT_MASK(EVENT_MASK)) u_status (
    .clk      (clk),
    .rst      (rst),
    .evt_pulse(evt_pulse),
    .lvl_cond (lvl_cond),
    .clr_stb  (wr_raw),
    .clr_bits (reg_wdata),
    .raw_o    (raw_vec)
  );

  isr_enable_mask #(.N_BITS(N_BITS)) u_enable (
    .clk    (clk),
    .rst    (rst),
    .set_stb(wr_set),
    .clr_stb(wr_clr),
    .bits   (reg_wdata),
    .en_o   (en_vec)
  );

  assign masked_vec = raw_vec & en_vec;

  isr_read_port #(.N_BITS(N_BITS)) u_read (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel),
    .raw   (raw_vec),
    .masked(masked_vec),
    .en    (en_vec),
    .rdata (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |masked_vec;
  end
endmodule

// File: rtl/isr_bank_chk.sv
module isr_bank_chk #(
  parameter int                N_BITS     = 8,
  parameter logic [N_BITS-1:0] EVENT_MASK = 8'h0F
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        reg_addr,
  input logic [N_BITS-1:0] reg_wdata,
  input logic              reg_wr,
  input logic [N_BITS-1:0] evt_pulse,
  input logic [N_BITS-1:0] reg_rdata,
  input logic              irq,
  input logic [N_BITS-1:0] raw_vec,
  input logic [N_BITS-1:0] en_vec
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (en_vec == '0 && irq == 1'b0 && (raw_vec & EVENT_MASK) == '0));

  p_masked_read_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd1) |=> (reg_rdata == $past(raw_vec & en_vec)));

  p_irq_lag_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past((raw_vec & en_vec) != '0)));

  p_event_set_r5: assert property (@(posedge clk) disable iff (rst)
    ((evt_pulse & EVENT_MASK) != '0) |=>
      ((raw_vec & $past(evt_pulse & EVENT_MASK)) == $past(evt_pulse & EVENT_MASK)));

  p_event_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0) |=>
      ((raw_vec & $past(reg_wdata & ~evt_pulse) & EVENT_MASK) == '0));

  p_en_set_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd2) |=> ((en_vec & $past(reg_wdata)) == $past(reg_wdata)));

  p_en_clr_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd3) |=> ((en_vec & $past(reg_wdata)) == '0));
endmodule

bind isr_bank isr_bank_chk #(.N_BITS(N_BITS), .EVENT_MASK(EVENT_MASK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_wr   (reg_wr),
  .evt_pulse(evt_pulse),
  .reg_rdata(reg_rdata),
  .irq      (irq),
  .raw_vec  (raw_vec),
  .en_vec   (en_vec)
);

// File: tb/tb_isr_bank.sv
module tb_isr_bank;
  localparam int N = 8;
  // bits 0..3 are event bits, bits 4..7 are level bits

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt_pulse = '0;
  logic [N-1:0] lvl_cond  = '0;
  logic [1:0]   reg_addr  = '0;
  logic [N-1:0] reg_wdata = '0;
  logic         reg_wr    = 1'b0;
  logic [N-1:0] reg_rdata;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  isr_bank #(.N_BITS(N), .EVENT_MASK(8'h0F)) dut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .lvl_cond(lvl_cond),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rdata", reg_rdata, 8'h00);
    rd(2'd0, v); chk("R1 raw", v, 8'h00);
    rd(2'd2, v); chk("R1 enable", v, 8'h00);
    rd(2'd1, v); chk("R1 masked", v, 8'h00);
  endtask

  task automatic t_event();
    logic [N-1:0] v;
    evt_pulse = 8'h05;
    @(negedge clk);
    evt_pulse = '0;
    @(negedge clk);
    rd(2'd0, v); chk("R5 event held", v, 8'h05);
    chk("R3 no enable no irq", {7'd0, irq}, 8'h00);
    rd(2'd3, v); chk("R9 mask via clear addr", v, 8'h00);
  endtask

  task automatic t_enable();
    logic [N-1:0] v;
    wr(2'd2, 8'h01);
    chk("R3 irq lags enable", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R3 irq after enable", {7'd0, irq}, 8'h01);
    rd(2'd0, v); chk("R4 raw unchanged by enable", v, 8'h05);
    rd(2'd1, v); chk("R2 masked", v, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd3, v); chk("R9 zero write keeps mask", v, 8'h01);
  endtask

  task automatic t_clear();
    logic [N-1:0] v;
    wr(2'd0, 8'h04);
    rd(2'd0, v); chk("R6 clear bit2", v, 8'h01);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R6 zero write keeps", v, 8'h01);
    wr(2'd0, 8'h01);
    chk("R3 irq lags clear", {7'd0, irq}, 8'h01);
    @(negedge clk);
    chk("R3 irq drops", {7'd0, irq}, 8'h00);
    rd(2'd0, v); chk("R6 clear bit0", v, 8'h00);
  endtask

  task automatic t_race();
    logic [N-1:0] v;
    evt_pulse = 8'h02;
    wr(2'd0, 8'h02);
    evt_pulse = '0;
    rd(2'd0, v); chk("R7 event wins over clear", v, 8'h02);
  endtask

  task automatic t_level();
    logic [N-1:0] v;
    lvl_cond = 8'h30;
    rd(2'd0, v); chk("R8 level follows input", v, 8'h32);
    wr(2'd0, 8'hF0);
    rd(2'd0, v); chk("R8 clear write ignored", v, 8'h32);
    wr(2'd1, 8'hFF);
    rd(2'd0, v); chk("R8 masked write ignored", v, 8'h32);
    wr(2'd2, 8'h10);
    @(negedge clk);
    chk("R3 irq from level", {7'd0, irq}, 8'h01);
    rd(2'd1, v); chk("R2 masked level", v, 8'h10);
    lvl_cond = 8'h00;
    @(negedge clk);
    chk("R3 irq after level drop", {7'd0, irq}, 8'h00);
    rd(2'd0, v); chk("R8 level cleared", v, 8'h02);
    wr(2'd0, 8'h40);
    rd(2'd0, v); chk("R8 cannot set level", v, 8'h02);
  endtask

  task automatic t_en_clear();
    logic [N-1:0] v;
    wr(2'd3, 8'h10);
    rd(2'd2, v); chk("R10 clear bit4", v, 8'h01);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R10 zero write keeps", v, 8'h01);
    wr(2'd0, 8'h02);
    rd(2'd2, v);
    chk("R11 rdata shows prior edge", reg_rdata, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_event();
    t_enable();
    t_clear();
    t_race();
    t_level();
    t_en_clear();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule